// File: doc/BRIEF.md
# Carrier-Gated Manchester Frame Receiver

This block takes a bi-phase-level (Manchester) serial line and turns it into a byte stream. It works only while an active-low carrier-detect input says a carrier is present. The frame ends when that carrier goes away, not at a flag or a character count. A sample-strobe input marks each half of a bit cell. The strobe may run at any rate up to one pulse every other clock, so the line is sampled at twice the bit rate or more, as seen from the system clock.

After carrier appears, the receiver hunts for an alternating preamble. It locks onto the first pair of consecutive ones, which acts as the start bit. From then on every decoded bit is data. Data bits are packed least significant bit first into 8-bit characters, with no parity, and each character is presented for one clock. The first character of a frame is marked.

A CRC-32 runs over every data bit, including the trailing 32-bit check field. When carrier drops, a one-clock done pulse presents a status word. The status word holds the CRC result, a short-preamble flag, a code-violation flag, a flag for a trailing partial character, and the count of data bits. A partial character is discarded. The receiver does not filter on address and does not recover a clock.

Top module: `mrx_rx`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it is released, `out_valid`, `out_sof` and `fr_done` are 0.
- R2: Carrier is present when `cd_n` is low. The receiver registers carrier each clock. A strobe is accepted only when the registered carrier is set. The first strobe accepted after carrier appears is the first half of a cell. Strobes taken without carrier produce no character and no done pulse.
- R3: Each cell is two accepted strobes, first half then second half. Halves (1,0) decode to bit 1 and halves (0,1) decode to bit 0.
- R4: While hunting, the receiver tracks the length of the current alternating run, saturating at 58. A second consecutive 1 starts the frame, and that second 1 is not data. The short-preamble flag, status bit 1, is set when the run that ends at the first of the two ones is shorter than 58 bits. Two zeros in a row restart the run at length 1.
- R5: Data bits are packed least significant bit first. On the clock after the strobe that completes the eighth bit, `out_valid` is high for one cycle with the character on `out_data`. `out_sof` is high with the first character of the frame and only then.
- R6: A cell whose halves are equal is a code violation and yields no bit. During the hunt it resets the run length to 0. Inside a frame it sets the code-error flag, status bit 2.
- R7: A CRC register initialised to all ones shifts each data bit in with polynomial 0x04C11DB7, using the form that compares the top bit. Status bit 0 is 1 when the register equals 0xC704DD7B at the end of the frame.
- R8: Carrier loss is a clock where the registered carrier is set and `cd_n` is high. If a start has been found, including on that same clock, `fr_done` is high for one cycle on the next clock with `fr_stat`. A strobe accepted on the carrier-loss clock still counts. Carrier loss during the hunt gives no done pulse.
- R9: `fr_stat[CNT_W+3:4]` holds the number of data bits, saturating at all ones. Status bit 3, the dribble flag, is set when a partial character of 1 to 7 bits remains at carrier loss. That partial character is never output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_in | input | 1 | Manchester-coded serial line |
| samp_en | input | 1 | Half-cell sample strobe |
| cd_n | input | 1 | Carrier detect, active low |
| out_valid | output | 1 | Character present on out_data |
| out_data | output | CHAR_W | Received character |
| out_sof | output | 1 | First character of the frame |
| fr_done | output | 1 | Frame ended, fr_stat valid |
| fr_stat | output | CNT_W+4 | {bit count, dribble, code error, short preamble, CRC ok} |

## Verification
The strobe that completes the last character and the carrier loss that ends the frame can fall on the same clock. The result is a character pulse and the done pulse together in the next cycle. The bench provokes this by raising `cd_n` on the same clock as the final half-cell strobe of the check field. It judges the outcome by requiring both pulses in one cycle, the full character sequence ending with the last check byte, a bit count that includes that character, a clear dribble flag and a good CRC. The clock-by-clock reference model confirms the same outcome.

// File: rtl/mrx_pkg.sv
package mrx_pkg;
  localparam logic [31:0] CRC_POLY    = 32'h04C11DB7;
  localparam logic [31:0] CRC_INIT    = 32'hFFFFFFFF;
  localparam logic [31:0] CRC_RESIDUE = 32'hC704DD7B;

  // one data bit into the running check register (top-bit compare form)
  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic b);
    return {c[30:0], 1'b0} ^ ((c[31] ^ b) ? CRC_POLY : 32'h0);
  endfunction

  // a cell without a mid-cell transition is a code violation
  function automatic logic cell_bad(input logic first_h, input logic second_h);
    return first_h == second_h;
  endfunction
endpackage

// File: rtl/mrx_cell.sv
module mrx_cell
  import mrx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic take,
  input  logic line,
  output logic cell_vld,
  output logic cell_bit,
  output logic cell_cv
);
  logic ph_q;   // 0: expecting first half
  logic h1_q;   // captured first half

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= 1'b0;
      h1_q <= 1'b0;
    end else if (clr) begin
      ph_q <= 1'b0;
      h1_q <= 1'b0;
    end else if (take) begin
      ph_q <= ~ph_q;
      if (!ph_q) h1_q <= line;
    end
  end

  assign cell_vld = take & ph_q;
  assign cell_bit = h1_q;
  assign cell_cv  = cell_vld & cell_bad(h1_q, line);
endmodule

// File: rtl/mrx_hunt.sv
module mrx_hunt #(
  parameter int unsigned MIN_PRE = 58
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic cell_vld,
  input  logic cell_bit,
  input  logic cell_cv,
  output logic in_frame,
  output logic start_evt,
  output logic short_nx
);
  localparam int unsigned RUN_W = $clog2(MIN_PRE + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(MIN_PRE);

  logic [RUN_W-1:0] run_q;
  logic prev_q, fr_q, short_q;
  logic hunt_bit;

  assign hunt_bit  = cell_vld & ~cell_cv & ~fr_q;
  assign start_evt = hunt_bit & (run_q != '0) & cell_bit & prev_q;
  assign short_nx  = start_evt ? (run_q < RUN_MAX) : short_q;
  assign in_frame  = fr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      prev_q  <= 1'b0;
      fr_q    <= 1'b0;
      short_q <= 1'b0;
    end else if (clr) begin
      run_q   <= '0;
      prev_q  <= 1'b0;
      fr_q    <= 1'b0;
      short_q <= 1'b0;
    end else if (cell_vld && !fr_q) begin
      if (cell_cv) begin
        run_q <= '0;
      end else if (start_evt) begin
        fr_q    <= 1'b1;
        short_q <= run_q < RUN_MAX;
      end else if (run_q == '0 || cell_bit != prev_q) begin
        run_q  <= (run_q == RUN_MAX) ? run_q : run_q + 1'b1;
        prev_q <= cell_bit;
      end else begin
        run_q  <= RUN_W'(1);
        prev_q <= cell_bit;
      end
    end
  end
endmodule

// File: rtl/mrx_assemble.sv
module mrx_assemble
  import mrx_pkg::*;
#(
  parameter int unsigned CHAR_W = 8,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              start_evt,
  input  logic              data_vld,
  input  logic              data_bit,
  input  logic              cv_evt,
  input  logic              fin,
  input  logic              short_nx,
  output logic              out_valid,
  output logic [CHAR_W-1:0] out_data,
  output logic              out_sof,
  output logic              fr_done,
  output logic [CNT_W+3:0]  fr_stat,
  output logic              char_done
);
  localparam int unsigned IDX_W = (CHAR_W > 1) ? $clog2(CHAR_W) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(CHAR_W - 1);

  logic [CHAR_W-1:0] sh_q, sh_nx;
  logic [IDX_W-1:0]  idx_q, idx_nx;
  logic [CNT_W-1:0]  cnt_q, cnt_nx;
  logic [31:0]       crc_q, crc_nx;
  logic              cv_q, cv_nx, first_q;

  assign char_done = data_vld & (idx_q == IDX_LAST);

  always_comb begin
    sh_nx  = sh_q;
    idx_nx = idx_q;
    cnt_nx = cnt_q;
    crc_nx = crc_q;
    if (data_vld) begin
      sh_nx  = {data_bit, sh_q[CHAR_W-1:1]};
      idx_nx = char_done ? '0 : idx_q + 1'b1;
      cnt_nx = (cnt_q == '1) ? cnt_q : cnt_q + 1'b1;
      crc_nx = crc_step(crc_q, data_bit);
    end
    cv_nx = cv_q | cv_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sof   <= 1'b0;
      fr_done   <= 1'b0;
      fr_stat   <= '0;
      sh_q      <= '0;
      idx_q     <= '0;
      cnt_q     <= '0;
      crc_q     <= CRC_INIT;
      cv_q      <= 1'b0;
      first_q   <= 1'b0;
    end else begin
      out_valid <= char_done;
      out_sof   <= char_done & first_q;
      if (char_done) out_data <= sh_nx;
      fr_done <= fin;
      if (fin) fr_stat <= {cnt_nx, (idx_nx != '0), cv_nx, short_nx, (crc_nx == CRC_RESIDUE)};
      if (clr) begin
        sh_q    <= '0;
        idx_q   <= '0;
        cnt_q   <= '0;
        crc_q   <= CRC_INIT;
        cv_q    <= 1'b0;
        first_q <= 1'b0;
      end else begin
        sh_q  <= sh_nx;
        idx_q <= idx_nx;
        cnt_q <= cnt_nx;
        crc_q <= crc_nx;
        cv_q  <= cv_nx;
        if (start_evt)      first_q <= 1'b1;
        else if (char_done) first_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mrx_rx.sv
module mrx_rx #(
  parameter int unsigned CHAR_W  = 8,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned MIN_PRE = 58
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_in,
  input  logic              samp_en,
  input  logic              cd_n,
  output logic              out_valid,
  output logic [CHAR_W-1:0] out_data,
  output logic              out_sof,
  output logic              fr_done,
  output logic [CNT_W+3:0]  fr_stat
);
  logic car_q;
  logic take, clr, car_lost;
  logic cell_vld, cell_bit, cell_cv;
  logic in_frame, start_evt, short_nx;
  logic data_vld, cv_evt, fin, char_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) car_q <= 1'b0;
    else        car_q <= ~cd_n;
  end

  assign take     = samp_en & car_q;
  assign clr      = ~car_q;
  assign car_lost = car_q & cd_n;
  assign data_vld = cell_vld & ~cell_cv & in_frame;
  assign cv_evt   = cell_cv & in_frame;
  assign fin      = car_lost & (in_frame | start_evt);

  mrx_cell u_cell (
    .clk(clk), .rst_n(rst_n), .clr(clr), .take(take), .line(line_in),
    .cell_vld(cell_vld), .cell_bit(cell_bit), .cell_cv(cell_cv)
  );

  mrx_hunt #(.MIN_PRE(MIN_PRE)) u_hunt (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .cell_vld(cell_vld), .cell_bit(cell_bit), .cell_cv(cell_cv),
    .in_frame(in_frame), .start_evt(start_evt), .short_nx(short_nx)
  );

  mrx_assemble #(.CHAR_W(CHAR_W), .CNT_W(CNT_W)) u_asm (
    .clk(clk), .rst_n(rst_n), .clr(clr), .start_evt(start_evt),
    .data_vld(data_vld), .data_bit(cell_bit), .cv_evt(cv_evt), .fin(fin),
    .short_nx(short_nx), .out_valid(out_valid), .out_data(out_data),
    .out_sof(out_sof), .fr_done(fr_done), .fr_stat(fr_stat), .char_done(char_done)
  );
endmodule

// File: rtl/mrx_rx_chk.sv
module mrx_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic cd_n,
  input logic out_valid,
  input logic out_sof,
  input logic fr_done,
  input logic in_frame,
  input logic cell_vld,
  input logic cell_cv
);
  a_r5_sof_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_valid);

  a_r4_chars_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_frame);

  a_r2_quiet_without_carrier: assert property (@(posedge clk) disable iff (!rst_n)
    (cd_n && $past(cd_n)) |=> (!out_valid && !fr_done));

  a_r6_violation_no_char: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_vld && cell_cv) |=> !out_valid);

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    fr_done |=> !fr_done);

  a_r8_done_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    fr_done |-> in_frame);
endmodule

bind mrx_rx mrx_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cd_n(cd_n), .out_valid(out_valid),
  .out_sof(out_sof), .fr_done(fr_done), .in_frame(in_frame),
  .cell_vld(cell_vld), .cell_cv(cell_cv)
);

// File: tb/tb_mrx_rx.sv
module tb_mrx_rx;
  localparam int CNT_W = 16;

  logic clk = 1'b0, rst_n = 1'b0, line_in = 1'b0, samp_en = 1'b0, cd_n = 1'b1;
  logic out_valid, out_sof, fr_done;
  logic [7:0] out_data;
  logic [CNT_W+3:0] fr_stat;

  always #4 clk = ~clk;   // 125 MHz

  mrx_rx dut (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .samp_en(samp_en), .cd_n(cd_n),
    .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
    .fr_done(fr_done), .fr_stat(fr_stat)
  );

  int vecs = 0, errs = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit e_valid, e_sof, e_done;
  logic [7:0] e_data;
  logic [CNT_W+3:0] e_stat;
  bit m_car, m_ph, m_h1, m_prev, m_in, m_short, m_cv, m_first;
  int m_run, m_cnt;
  bit bq[$];
  logic [31:0] m_r;

  function automatic logic [31:0] refl(input logic [31:0] r, input bit b);
    return (r >> 1) ^ ((r[0] ^ b) ? 32'hEDB88320 : 32'h0);
  endfunction

  task automatic m_clear();
    m_ph = 0; m_h1 = 0; m_prev = 0; m_in = 0; m_short = 0; m_cv = 0; m_first = 0;
    m_run = 0; m_cnt = 0; bq.delete(); m_r = 32'hFFFFFFFF;
  endtask

  task automatic m_cell(input bit a, input bit s);
    if (a == s) begin
      if (m_in) m_cv = 1; else m_run = 0;
    end else if (m_in) begin
      bq.push_back(a);
      if (m_cnt < 65535) m_cnt++;
      m_r = refl(m_r, a);
      if (bq.size() == 8) begin
        e_valid = 1;
        for (int k = 0; k < 8; k++) e_data[k] = bq[k];
        e_sof = m_first; m_first = 0;
        bq.delete();
      end
    end else if (m_run > 0 && a && m_prev) begin
      m_in = 1; m_short = (m_run < 58); m_first = 1;
    end else if (m_run == 0 || a != m_prev) begin
      if (m_run < 58) m_run++;
      m_prev = a;
    end else begin
      m_run = 1; m_prev = a;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_clear(); m_car = 0; e_valid = 0; e_sof = 0; e_done = 0; e_data = 0; e_stat = 0;
    end else begin
      e_valid = 0; e_sof = 0; e_done = 0;
      if (!m_car) m_clear();
      else begin
        if (samp_en) begin
          if (!m_ph) begin m_h1 = line_in; m_ph = 1; end
          else begin m_ph = 0; m_cell(m_h1, line_in); end
        end
        if (cd_n && m_in) begin
          e_done = 1;
          e_stat = {m_cnt[CNT_W-1:0], bit'(bq.size() != 0), m_cv, m_short, bit'(m_r == 32'hDEBB20E3)};
        end
      end
      m_car = !cd_n;
    end
  end

  // ---------------- per-clock compare and capture ----------------
  logic [7:0] rxq[$];
  int ndone = 0;
  logic [CNT_W+3:0] last_stat;

  always @(negedge clk) begin
    if (rst_n) begin
      chk(out_valid === e_valid, "R2/R5 out_valid", out_valid, e_valid);
      if (e_valid) begin
        chk(out_data === e_data, "R3/R5 out_data", out_data, e_data);
        chk(out_sof === e_sof, "R5 out_sof", out_sof, e_sof);
      end
      chk(fr_done === e_done, "R8 fr_done", fr_done, e_done);
      if (e_done) begin
        chk(fr_stat[0] === e_stat[0], "R7 crc_ok", fr_stat[0], e_stat[0]);
        chk(fr_stat[1] === e_stat[1], "R4 short", fr_stat[1], e_stat[1]);
        chk(fr_stat[2] === e_stat[2], "R6 code_err", fr_stat[2], e_stat[2]);
        chk(fr_stat[3] === e_stat[3], "R9 dribble", fr_stat[3], e_stat[3]);
        chk(fr_stat[CNT_W+3:4] === e_stat[CNT_W+3:4], "R9 bit_count",
            fr_stat[CNT_W+3:4], e_stat[CNT_W+3:4]);
      end
      if (out_valid) rxq.push_back(out_data);
      if (fr_done) begin ndone++; last_stat = fr_stat; end
    end
  end

  // ---------------- stimulus ----------------
  task automatic half(input bit v, input bit drop);
    @(negedge clk); line_in = v; samp_en = 1'b1; if (drop) cd_n = 1'b1;
    @(negedge clk); samp_en = 1'b0;
  endtask

  task automatic build(ref bit q[$], input int pre_len, input bit pre_first,
                       input logic [7:0] dq[$], input bit corrupt, input int extra,
                       input bit with_body);
    logic [31:0] r;
    q.delete();
    for (int i = 0; i < pre_len; i++) q.push_back(pre_first ^ bit'(i % 2));
    if (!with_body) return;
    q.push_back(1); q.push_back(1);
    r = 32'hFFFFFFFF;
    foreach (dq[i]) for (int k = 0; k < 8; k++) begin
      q.push_back(dq[i][k]); r = refl(r, dq[i][k]);
    end
    r = ~r;
    for (int k = 0; k < 32; k++) q.push_back(r[k]);
    if (corrupt) q[pre_len + 2 + 3] = ~q[pre_len + 2 + 3];
    for (int i = 0; i < extra; i++) q.push_back(bit'(i % 2));
  endtask

  task automatic send(input bit q[$], input bit tight, input int viol_at);
    rxq.delete();
    @(negedge clk); cd_n = 1'b0;
    @(negedge clk);
    foreach (q[i]) begin
      bit last = (i == q.size() - 1);
      if (i == viol_at) begin half(q[i], 0); half(q[i], tight && last); end
      else begin half(q[i], 0); half(~q[i], tight && last); end
    end
    if (!tight) begin repeat (3) @(negedge clk); cd_n = 1'b1; end
    repeat (6) @(negedge clk);
  endtask

  task automatic expect_frame(input string name, input int d0, input logic [7:0] dq[$],
                              input bit crc, input bit shrt, input bit cv, input bit drib,
                              input int cnt, input bit chk_bytes);
    chk(ndone == d0 + 1, {"R8 one done ", name}, ndone, d0 + 1);
    chk(last_stat[0] == crc, {"R7 crc ", name}, last_stat[0], crc);
    chk(last_stat[1] == shrt, {"R4 short ", name}, last_stat[1], shrt);
    chk(last_stat[2] == cv, {"R6 code ", name}, last_stat[2], cv);
    chk(last_stat[3] == drib, {"R9 dribble ", name}, last_stat[3], drib);
    if (cnt >= 0) chk(last_stat[CNT_W+3:4] == cnt, {"R9 count ", name}, last_stat[CNT_W+3:4], cnt);
    if (chk_bytes) begin
      chk(rxq.size() == dq.size() + 4, {"R5 nchars ", name}, rxq.size(), dq.size() + 4);
      foreach (dq[i]) if (i < rxq.size())
        chk(rxq[i] == dq[i], {"R3 char ", name}, rxq[i], dq[i]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    bit q[$];
    logic [7:0] dq[$];
    int d0;
    dq = '{8'hA5, 8'h00, 8'hFF, 8'h3C, 8'h81, 8'h7E};
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0 && out_sof === 1'b0 && fr_done === 1'b0, "R1 reset outputs",
        {out_valid, out_sof, fr_done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b0 && fr_done === 1'b0, "R1 after release", {out_valid, fr_done}, 0);

    // R2: strobes with no carrier
    for (int i = 0; i < 40; i++) half(bit'(i % 3 == 0), 0);
    chk(rxq.size() == 0 && ndone == 0, "R2 no carrier", rxq.size() + ndone, 0);

    d0 = ndone; build(q, 62, 1, dq, 0, 0, 1); send(q, 0, -1);
    expect_frame("good", d0, dq, 1, 0, 0, 0, 80, 1);

    d0 = ndone; build(q, 62, 1, dq, 0, 0, 1); send(q, 1, -1);
    expect_frame("same-cycle end", d0, dq, 1, 0, 0, 0, 80, 1);

    d0 = ndone; build(q, 56, 1, dq, 0, 0, 1); send(q, 0, -1);
    expect_frame("run57", d0, dq, 1, 1, 0, 0, 80, 1);

    d0 = ndone; build(q, 57, 0, dq, 0, 0, 1); send(q, 0, -1);
    expect_frame("run58", d0, dq, 1, 0, 0, 0, 80, 1);

    d0 = ndone; build(q, 62, 1, dq, 1, 0, 1); send(q, 1, -1);
    expect_frame("bad crc", d0, dq, 0, 0, 0, 0, 80, 0);

    d0 = ndone; build(q, 62, 1, dq, 0, 3, 1); send(q, 0, -1);
    chk(ndone == d0 + 1 && last_stat[3] == 1'b1, "R9 dribble flag", last_stat[3], 1);
    chk(last_stat[CNT_W+3:4] == 83, "R9 dribble count", last_stat[CNT_W+3:4], 83);
    chk(rxq.size() == 10, "R9 partial dropped", rxq.size(), 10);

    d0 = ndone; build(q, 62, 1, dq, 0, 0, 1); send(q, 0, 62 + 2 + 12);
    chk(ndone == d0 + 1 && last_stat[2] == 1'b1, "R6 in-frame violation", last_stat[2], 1);
    chk(last_stat[CNT_W+3:4] == 79, "R6 violating cell no bit", last_stat[CNT_W+3:4], 79);

    d0 = ndone; build(q, 62, 1, dq, 0, 0, 1); send(q, 0, 10);
    expect_frame("hunt violation", d0, dq, 1, 1, 0, 0, 80, 1);

    d0 = ndone; build(q, 30, 1, dq, 0, 0, 0); send(q, 1, -1);
    chk(ndone == d0 && rxq.size() == 0, "R8 loss while hunting", ndone - d0, 0);

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule